// File: doc/BRIEF.md
# Serial Converter Transaction Host

This block is the host end of a four-wire serial link to a sampling analog-to-digital converter. Each transaction lowers chip-select and produces a serial clock from the system clock through a programmable half-period divider. It shifts out an 8-bit command MSB first and shifts in a 16-bit conversion result MSB first. At the end it raises chip-select again and holds it high for a programmable idle time before it accepts another request.

User logic gets a one-cycle result-valid pulse together with the captured word. A `start`/`ready` pair gates new requests. A framing input picks a short frame of 24 serial clocks or a long frame of 32 serial clocks. The long frame gives the converter eight extra clocks of acquisition before the result appears. An `abort` input ends a frame at once by raising chip-select. This also stops the conversion in the converter.

Top module: `adc_spi_host`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cs_n`=1, `sclk`=0, `mosi`=0, `result_valid`=0 and `ready`=1.
- R2: A `start` sampled high on a clock edge where `ready` is high makes `cs_n` go low after that edge. `start` while `ready` is low is ignored.
- R3: Inside a frame, `sclk` begins low and toggles every H system clocks, where H is `half_div`, or 1 when `half_div` is 0. This gives an exact 50% duty cycle. `sclk` is low whenever `cs_n` is high.
- R4: A frame has 24 `sclk` rising edges when `wide_mode`=0 and 32 when `wide_mode`=1. `cs_n` rises on the edge that ends the last high phase.
- R5: Command bit 7 is on `mosi` from the start edge. Bits 6..0 follow, one on each `sclk` falling edge. `mosi` never changes while `sclk` is high, and it is 0 after the eighth bit and outside a frame.
- R6: `miso` is captured on the system edge that raises `sclk`. The result is built from rising edges 9..24 (`wide_mode`=0) or 17..32 (`wide_mode`=1), first captured bit in bit 15.
- R7: `result_valid` is high for exactly one cycle, the cycle in which `cs_n` has just risen after a complete frame, and `result` holds the captured word then.
- R8: After `cs_n` rises, `ready` stays low for `idle_cnt` cycles, so `cs_n` stays high for at least `idle_cnt`+1 cycles. `ready` is low throughout a frame.
- R9: `abort` high during a frame raises `cs_n` and lowers `sclk` and `mosi` on the next edge, gives no `result_valid`, and starts the idle time. `abort` outside a frame has no effect.
- R10: `cmd`, `wide_mode` and `half_div` are taken at the start edge. Changes to them during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transaction |
| ready | output | 1 | Idle and idle time elapsed; `start` accepted |
| cmd | input | 8 | Command byte sent MSB first |
| wide_mode | input | 1 | 0: 24-clock frame, 1: 32-clock frame |
| half_div | input | DIV_W | Serial-clock half period in system clocks (0 acts as 1) |
| idle_cnt | input | IDLE_W | Minimum chip-select high time in system clocks |
| abort | input | 1 | Force chip-select high mid-frame |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial command data to the converter |
| miso | input | 1 | Serial result data from the converter |
| result | output | 16 | Last captured conversion word |
| result_valid | output | 1 | One-cycle pulse with a new `result` |

## Verification
The assertions assume that `miso` is a plain synchronous input and that `start` and `abort` are single-bit requests with no ordering between them. They also assume that `half_div` and `idle_cnt` only have to be held steady on the edges where the block takes them. The stimulus changes every input a short time after a rising edge, so each input is stable on the next edge. The bench's converter model changes `miso` only while `sclk` is low, one bit per serial period. Outside the result window it drives ones, so a capture at the wrong offset shows up in the result word. Mid-frame changes to the command, mode and divider, extra `start` pulses during a frame, and `abort` pulses both in and out of a frame are all applied on purpose.

// File: rtl/adc_spi_host.sv
module adc_spi_host #(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  input  logic [7:0]        cmd,
  input  logic              wide_mode,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [IDLE_W-1:0] idle_cnt,
  input  logic              abort,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [15:0]       result,
  output logic              result_valid
);
  localparam int CNT_W = 6;

  logic              busy, wide_q, sclk_q, cs_q, mosi_q, valid_q;
  logic [DIV_W-1:0]  div_q, ph;
  logic [CNT_W-1:0]  edges;
  logic [7:0]        cmd_sh;
  logic [15:0]       res_sh, result_q;
  logic [IDLE_W-1:0] idle_left;

  wire [CNT_W-1:0] frame_len = wide_q ? CNT_W'(32) : CNT_W'(24);
  wire [CNT_W-1:0] first_rx  = frame_len - CNT_W'(16);
  wire             tick      = (ph == div_q - DIV_W'(1));

  assign ready        = !busy && (idle_left == '0);
  assign cs_n         = cs_q;
  assign sclk         = sclk_q;
  assign mosi         = mosi_q;
  assign result       = result_q;
  assign result_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wide_q    <= 1'b0;
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      mosi_q    <= 1'b0;
      valid_q   <= 1'b0;
      div_q     <= DIV_W'(1);
      ph        <= '0;
      edges     <= '0;
      cmd_sh    <= '0;
      res_sh    <= '0;
      result_q  <= '0;
      idle_left <= '0;
    end else begin
      valid_q <= 1'b0;
      if (busy) begin
        if (abort) begin
          busy      <= 1'b0;
          cs_q      <= 1'b1;
          sclk_q    <= 1'b0;
          mosi_q    <= 1'b0;
          idle_left <= idle_cnt;
        end else if (tick) begin
          ph <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            edges  <= edges + CNT_W'(1);
            if (edges >= first_rx) res_sh <= {res_sh[14:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (edges == frame_len) begin
              busy      <= 1'b0;
              cs_q      <= 1'b1;
              mosi_q    <= 1'b0;
              valid_q   <= 1'b1;
              result_q  <= res_sh;
              idle_left <= idle_cnt;
            end else begin
              mosi_q <= cmd_sh[7];
              cmd_sh <= {cmd_sh[6:0], 1'b0};
            end
          end
        end else begin
          ph <= ph + DIV_W'(1);
        end
      end else if (ready && start) begin
        busy   <= 1'b1;
        cs_q   <= 1'b0;
        sclk_q <= 1'b0;
        ph     <= '0;
        edges  <= '0;
        wide_q <= wide_mode;
        div_q  <= (half_div == '0) ? DIV_W'(1) : half_div;
        mosi_q <= cmd[7];
        cmd_sh <= {cmd[6:0], 1'b0};
      end else if (idle_left != '0) begin
        idle_left <= idle_left - IDLE_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_spi_host_chk.sv
module adc_spi_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ready,
  input logic abort,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic result_valid
);
  assert_start_lowers_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready |=> !cs_n);

  assert_sclk_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(mosi));

  assert_valid_on_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && !$past(cs_n)));

  assert_ready_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cs_n);

  assert_abort_ends_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !cs_n |=> cs_n && !sclk && !result_valid);
endmodule

bind adc_spi_host adc_spi_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .abort(abort),
  .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .result_valid(result_valid)
);

// File: tb/sim_adc_spi_host.sv
module sim_adc_spi_host;
  logic clk = 0, rst_n = 0, start = 0, wide_mode = 0, abort = 0, miso = 0;
  logic [7:0]  cmd = 0, half_div = 1, idle_cnt = 0;
  logic        ready, cs_n, sclk, mosi, result_valid;
  logic [15:0] result, tgt_data = 0;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  adc_spi_host u0 (.clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .cmd(cmd),
    .wide_mode(wide_mode), .half_div(half_div), .idle_cnt(idle_cnt), .abort(abort),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .result(result),
    .result_valid(result_valid));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, state after the most recent rising edge
  bit m_busy = 0, m_valid = 0;
  int m_k = 0, m_D = 1, m_N = 24, m_idle = 0;
  logic [7:0]  m_cmd = 0;
  logic [15:0] m_data = 0, last_res = 0;
  bit got_valid = 0;
  logic p_start = 0, p_abort = 0, p_wide = 0;
  logic [7:0] p_cmd = 0, p_div = 1, p_idle = 0;
  logic [15:0] p_data = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_idle = 0; m_k = 0;
      p_start = 0; p_abort = 0;
    end else begin
      bit m_ready;
      int b, e_sclk, e_mosi;
      m_ready = !m_busy && m_idle == 0;
      m_valid = 0;
      if (m_busy) begin
        if (p_abort) begin
          m_busy = 0; m_idle = p_idle;
        end else begin
          m_k++;
          if (m_k == 2 * m_D * m_N) begin
            m_busy = 0; m_valid = 1; m_idle = p_idle;
          end
        end
      end else if (m_ready && p_start) begin
        m_busy = 1; m_k = 0; m_cmd = p_cmd; m_N = p_wide ? 32 : 24;
        m_D = (p_div == 0) ? 1 : p_div; m_data = p_data;
      end else if (m_idle > 0) m_idle--;

      b = m_k / (2 * m_D);
      e_sclk = m_busy ? (m_k / m_D) % 2 : 0;
      e_mosi = (m_busy && b < 8) ? m_cmd[7-b] : 0;
      chk(cs_n == !m_busy, "R2 R4 R9 cs_n", cs_n, !m_busy);
      chk(sclk == e_sclk, "R3 R4 sclk", sclk, e_sclk);
      chk(mosi == e_mosi, "R5 mosi", mosi, e_mosi);
      chk(ready == (!m_busy && m_idle == 0), "R8 ready", ready, !m_busy && m_idle == 0);
      chk(result_valid == m_valid, "R7 R9 result_valid", result_valid, m_valid);
      if (m_valid) begin
        chk(result == m_data, "R6 R7 result", result, m_data);
        last_res = result; got_valid = 1;
      end
      // converter model: ones outside the result window expose a wrong offset
      if (m_busy && b >= m_N - 16) miso <= m_data[15 - (b - (m_N - 16))];
      else miso <= 1'b1;
      p_start = start; p_abort = abort; p_cmd = cmd; p_wide = wide_mode;
      p_div = half_div; p_idle = idle_cnt; p_data = tgt_data;
    end
  end

  task automatic wait_ready();
    do begin @(posedge clk); #2; end while (!ready);
  endtask

  task automatic txn(input logic [7:0] c, input bit w, input logic [7:0] d,
                     input logic [7:0] idl, input logic [15:0] data,
                     input int abort_after, input bit disturb);
    cmd = c; wide_mode = w; half_div = d; idle_cnt = idl; tgt_data = data;
    got_valid = 0;
    wait_ready();
    start = 1;
    @(posedge clk); #2;
    start = 0;
    if (disturb) begin
      // R10: later changes to cmd/mode/divider must not alter the frame; R2: start while busy ignored
      cmd = ~c; wide_mode = ~w; half_div = d + 2;
      repeat (5) @(posedge clk); #2;
      start = 1; @(posedge clk); #2; start = 0;
    end
    if (abort_after >= 0) begin
      repeat (abort_after) @(posedge clk); #2;
      abort = 1; @(posedge clk); #2; abort = 0;
    end
    while (!cs_n) begin @(posedge clk); #2; end
    repeat (2) @(posedge clk); #2;
    if (abort_after < 0) begin
      chk(got_valid && last_res == data, "R6 R10 word", last_res, data);
    end else begin
      chk(!got_valid, "R9 no result after abort", got_valid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      chk(0, "R4 watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #8;
    // R1 during reset
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && result_valid == 0, "R1 reset outputs",
        {cs_n, sclk, mosi, result_valid}, 4'b1000);
    @(posedge clk); #2; rst_n = 1;
    @(posedge clk); #2;
    chk(ready == 1 && cs_n == 1, "R1 ready after reset", {ready, cs_n}, 2'b11);

    txn(8'hA5, 0, 1, 0, 16'hBEEF, -1, 0);
    txn(8'h3C, 0, 3, 5, 16'h8001, -1, 0);
    txn(8'hC3, 1, 2, 3, 16'h1234, -1, 0);
    txn(8'h81, 1, 0, 2, 16'h7FFE, -1, 0);
    txn(8'h5A, 0, 2, 4, 16'hF00F, -1, 1);
    txn(8'hE7, 1, 1, 6, 16'h55AA, -1, 1);
    txn(8'h99, 0, 2, 4, 16'hCAFE, 20, 0);
    txn(8'h66, 1, 3, 0, 16'h0F0F, 150, 0);
    txn(8'hFF, 1, 1, 0, 16'hFFFF, -1, 0);
    txn(8'h00, 0, 1, 0, 16'h0000, -1, 0);
    // R9: abort outside a frame has no effect
    wait_ready();
    abort = 1; repeat (3) @(posedge clk); #2; abort = 0;
    chk(cs_n == 1 && ready == 1, "R9 idle abort ignored", {cs_n, ready}, 2'b11);
    txn(8'h42, 0, 4, 7, 16'hA5A5, -1, 0);
    repeat (10) @(posedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule